// File: doc/BRIEF.md
# Three-Slot Packed-Instruction Execution Core

This block is a small 16-bit load/store processor core. Every 16-bit opcode is split into three fields, one for each instruction group: a transfer group (memory access, address and flag moves, jumps through AX), an arithmetic group (increment, decrement, add, swap, constant load) and a flow group (conditional relative branch, flag set and clear). All three field instructions of one opcode complete together in a single clock. None of them takes an operand, and there are no addressing modes. Memory is reached only through the address register MA.

The core has separate code and data ports. The instruction pointer drives `code_addr`, and the opcode for that address is expected on `code_rdata` in the same cycle. MA drives `data_addr`. Load data is expected on `data_rdata` in the same cycle, and a store raises `data_we` for one cycle with the value on `data_wdata`. Every field reads the register values as they stood before the edge, so the three fields of an opcode act as one parallel assignment. A tool that packs the opcodes must not place two writes to the same register in one opcode. The core does not check for this.

Top module: `tri_slot_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, AX, BX, DX, LX, MA, IP and CF all clear to zero, so `code_addr` and `data_addr` read 0 after reset.
- R2: `code_addr` always shows IP. When no field of the opcode writes IP, IP increments by one per cycle and wraps from 16'hFFFF to 0.
- R3: The transfer field is opcode bits [4:0], the arithmetic field is bits [9:5] and the flow field is bits [15:10]. In every field, code 0 and any code above the highest code listed for that group are a NOP. Opcode 16'hFFFF therefore changes nothing except the normal IP increment.
- R4: Transfer codes 1, 2 and 3 load AX, DX and LX respectively from `data_rdata`, which is the word at `data_addr`.
- R5: Transfer codes 4, 5, 6 and 7 store AX, BX, DX and LX respectively. During that opcode `data_we` is 1 and `data_wdata` carries the register. `data_we` is 0 for every other transfer code.
- R6: Transfer code 8 copies AX into MA and transfer code 9 copies DX into MA. `data_addr` shows MA.
- R7: Transfer code 10 sets CF to 1 when BX is non-zero and clears CF to 0 when BX is zero.
- R8: Flow code 1 is a conditional relative branch. When CF is 1, the next IP is the opcode's own address plus LX, modulo 2^16, so LX = 16'hFFFF repeats the previous opcode. When CF is 0 the normal increment applies.
- R9: Transfer code 11 copies AX into IP.
- R10: Arithmetic codes 1, 2, 3 and 4 perform AX+1, AX-1, BX+1 and BX-1 respectively. Arithmetic code 7 performs AX <= AX+BX. All of these wrap modulo 2^16.
- R11: Arithmetic code 5 exchanges DX and BX. Arithmetic code 6 loads LX with 16'hFFFF.
- R12: All fields of one opcode read the values that registers and CF held before the clock edge, and all results are written at that edge. A field that reads a register another field writes in the same opcode sees the old value.
- R13: Flow code 2 clears CF and flow code 3 sets CF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| code_addr | output | 16 | Code memory address (the current IP) |
| code_rdata | input | 16 | Opcode at `code_addr`, valid in the same cycle |
| data_addr | output | 16 | Data memory address (the current MA) |
| data_rdata | input | 16 | Data word at `data_addr`, valid in the same cycle |
| data_we | output | 1 | Data write strobe for the current opcode |
| data_wdata | output | 16 | Store value, meaningful while `data_we` is 1 |

## Verification
The case that matters is one field reading a register that another field writes in the same opcode. Examples are a store of BX next to a DX/BX exchange, a BX-to-CF move next to a BX decrement, and an AX-to-MA move next to an AX increment. The bench places such pairs in single opcodes and sweeps every legal combination of transfer, arithmetic and flow codes, including unused codes. After each opcode it stores all four data registers. It judges each result against a parallel-assignment model that computes every field from the values held before the opcode.

// File: rtl/tri_slot_pkg.sv
// Package: shared widths, register indices, per-group opcode codes and the
// write-bundle type each execution slot hands to the register file.
// Assumes a 16-bit word and three fields; the last field takes the leftover bits.
package tri_slot_pkg;

    localparam int WORD_W    = 16;
    localparam int FIELD_W   = 5;
    localparam int NUM_SLOTS = 3;
    localparam int LAST_W    = WORD_W - (NUM_SLOTS - 1) * FIELD_W;

    localparam int REG_AX = 0;
    localparam int REG_BX = 1;
    localparam int REG_DX = 2;
    localparam int REG_LX = 3;
    localparam int REG_MA = 4;
    localparam int REG_IP = 5;
    localparam int NREG   = 6;

    localparam int SLOT_XFER  = 0;
    localparam int SLOT_ARITH = 1;
    localparam int SLOT_FLOW  = 2;

    typedef logic [WORD_W-1:0]            word_t;
    typedef logic [FIELD_W-1:0]           field_t;
    typedef logic [NREG-1:0][WORD_W-1:0]  regs_t;

    typedef enum logic [FIELD_W-1:0] {
        X_NOP   = 5'd0,
        X_LD_AX = 5'd1,
        X_LD_DX = 5'd2,
        X_LD_LX = 5'd3,
        X_ST_AX = 5'd4,
        X_ST_BX = 5'd5,
        X_ST_DX = 5'd6,
        X_ST_LX = 5'd7,
        X_AX_MA = 5'd8,
        X_DX_MA = 5'd9,
        X_BX_CF = 5'd10,
        X_AX_IP = 5'd11
    } xfer_e;

    typedef enum logic [FIELD_W-1:0] {
        A_NOP    = 5'd0,
        A_INC_AX = 5'd1,
        A_DEC_AX = 5'd2,
        A_INC_BX = 5'd3,
        A_DEC_BX = 5'd4,
        A_XCH    = 5'd5,
        A_LX_M1  = 5'd6,
        A_ADD_BX = 5'd7
    } arith_e;

    typedef enum logic [FIELD_W-1:0] {
        F_NOP    = 5'd0,
        F_CAD    = 5'd1,
        F_CLR_CF = 5'd2,
        F_SET_CF = 5'd3
    } flow_e;

    // Highest defined code of a group; anything above decodes as NOP.
    function automatic field_t slot_last(input int slot);
        case (slot)
            SLOT_XFER:  return X_AX_IP;
            SLOT_ARITH: return A_ADD_BX;
            default:    return F_SET_CF;
        endcase
    endfunction

    typedef struct packed {
        logic [NREG-1:0] wen;
        regs_t           wval;
        logic            cf_wen;
        logic            cf_val;
    } slot_wr_t;

endpackage

// File: rtl/xfer_slot.sv
// Transfer-group execution: loads and stores through MA, moves into MA,
// BX-to-flag test and the absolute jump from AX.
// Assumes the code is already validated (unknown codes arrive as NOP).
module xfer_slot
    import tri_slot_pkg::*;
(
    input  field_t   code,
    input  word_t    ax,
    input  word_t    bx,
    input  word_t    dx,
    input  word_t    lx,
    input  word_t    rdata,
    output slot_wr_t wr,
    output logic     st_en,
    output word_t    st_val
);

    // Decode one transfer code into register writes and a store request.
    always_comb begin
        wr     = '0;
        st_en  = 1'b0;
        st_val = '0;
        case (code)
            X_LD_AX: begin wr.wen[REG_AX] = 1'b1; wr.wval[REG_AX] = rdata; end
            X_LD_DX: begin wr.wen[REG_DX] = 1'b1; wr.wval[REG_DX] = rdata; end
            X_LD_LX: begin wr.wen[REG_LX] = 1'b1; wr.wval[REG_LX] = rdata; end
            X_ST_AX: begin st_en = 1'b1; st_val = ax; end
            X_ST_BX: begin st_en = 1'b1; st_val = bx; end
            X_ST_DX: begin st_en = 1'b1; st_val = dx; end
            X_ST_LX: begin st_en = 1'b1; st_val = lx; end
            X_AX_MA: begin wr.wen[REG_MA] = 1'b1; wr.wval[REG_MA] = ax; end
            X_DX_MA: begin wr.wen[REG_MA] = 1'b1; wr.wval[REG_MA] = dx; end
            X_BX_CF: begin wr.cf_wen = 1'b1; wr.cf_val = |bx; end
            X_AX_IP: begin wr.wen[REG_IP] = 1'b1; wr.wval[REG_IP] = ax; end
            default: ;
        endcase
    end

endmodule

// File: rtl/arith_slot.sv
// Arithmetic-group execution: +1/-1 on AX and BX, AX+BX, DX/BX exchange and
// the all-ones constant into LX. All results wrap at the word width.
// Assumes the code is already validated (unknown codes arrive as NOP).
module arith_slot
    import tri_slot_pkg::*;
(
    input  field_t   code,
    input  word_t    ax,
    input  word_t    bx,
    input  word_t    dx,
    output slot_wr_t wr
);

    localparam word_t ONE = word_t'(1);

    // Decode one arithmetic code into register writes.
    always_comb begin
        wr = '0;
        case (code)
            A_INC_AX: begin wr.wen[REG_AX] = 1'b1; wr.wval[REG_AX] = ax + ONE; end
            A_DEC_AX: begin wr.wen[REG_AX] = 1'b1; wr.wval[REG_AX] = ax - ONE; end
            A_INC_BX: begin wr.wen[REG_BX] = 1'b1; wr.wval[REG_BX] = bx + ONE; end
            A_DEC_BX: begin wr.wen[REG_BX] = 1'b1; wr.wval[REG_BX] = bx - ONE; end
            A_XCH: begin
                wr.wen[REG_BX]  = 1'b1;
                wr.wval[REG_BX] = dx;
                wr.wen[REG_DX]  = 1'b1;
                wr.wval[REG_DX] = bx;
            end
            A_LX_M1:  begin wr.wen[REG_LX] = 1'b1; wr.wval[REG_LX] = '1; end
            A_ADD_BX: begin wr.wen[REG_AX] = 1'b1; wr.wval[REG_AX] = ax + bx; end
            default: ;
        endcase
    end

endmodule

// File: rtl/flow_slot.sv
// Flow-group execution: branch relative to the current opcode address by LX
// when the flag is set, plus explicit flag clear and set.
// Assumes the code is already validated (unknown codes arrive as NOP).
module flow_slot
    import tri_slot_pkg::*;
(
    input  field_t   code,
    input  word_t    ip,
    input  word_t    lx,
    input  logic     cf,
    output slot_wr_t wr
);

    // Decode one flow code into an IP override or a flag write.
    always_comb begin
        wr = '0;
        case (code)
            F_CAD: begin
                wr.wen[REG_IP]  = cf;
                wr.wval[REG_IP] = ip + lx;
            end
            F_CLR_CF: begin wr.cf_wen = 1'b1; wr.cf_val = 1'b0; end
            F_SET_CF: begin wr.cf_wen = 1'b1; wr.cf_val = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/slot_regfile.sv
// Register file: holds AX, BX, DX, LX, MA, IP and CF, merges the write
// bundles of all slots at the clock edge and steps IP when nobody writes it.
// Assumes at most one slot writes a given register per cycle (not checked).
module slot_regfile
    import tri_slot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  slot_wr_t wr [NUM_SLOTS],
    output regs_t    regs,
    output logic     cf
);

    logic cf_q;
    logic cf_nxt;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam word_t STEP = (r == REG_IP) ? word_t'(1) : word_t'(0);
        word_t q;
        word_t nxt;

        // Pick the slot write for this register, else hold (or step for IP).
        always_comb begin
            nxt = q + STEP;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr[s].wen[r]) nxt = wr[s].wval[r];
            end
        end

        // Register update with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt;
        end

        assign regs[r] = q;
    end

    // Pick the slot write for the condition flag, else hold.
    always_comb begin
        cf_nxt = cf_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (wr[s].cf_wen) cf_nxt = wr[s].cf_val;
        end
    end

    // Flag update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cf_q <= 1'b0;
        else        cf_q <= cf_nxt;
    end

    assign cf = cf_q;

endmodule

// File: rtl/tri_slot_core.sv
// Top of the three-slot core: splits the fetched opcode into its group
// fields, turns unknown codes into NOP, runs the three slots side by side on
// the pre-edge register values and commits through the register file.
// Assumes code and data memories answer combinationally in the same cycle.
module tri_slot_core
    import tri_slot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [WORD_W-1:0]   code_addr,
    input  logic [WORD_W-1:0]   code_rdata,
    output logic [WORD_W-1:0]   data_addr,
    input  logic [WORD_W-1:0]   data_rdata,
    output logic                data_we,
    output logic [WORD_W-1:0]   data_wdata
);

    field_t   slot_code [NUM_SLOTS];
    slot_wr_t slot_wr   [NUM_SLOTS];
    regs_t    regs_q;
    logic     cf_q;
    logic     st_en;
    word_t    st_val;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_field
        localparam field_t LAST = slot_last(g);
        if (g < NUM_SLOTS - 1) begin : g_narrow
            field_t raw;
            assign raw          = code_rdata[g*FIELD_W +: FIELD_W];
            assign slot_code[g] = (raw <= LAST) ? raw : '0;
        end else begin : g_wide
            logic [LAST_W-1:0] raw;
            assign raw          = code_rdata[WORD_W-1 -: LAST_W];
            assign slot_code[g] = (raw <= LAST_W'(LAST)) ? raw[FIELD_W-1:0] : '0;
        end
    end

    xfer_slot u_xfer (
        .code   (slot_code[SLOT_XFER]),
        .ax     (regs_q[REG_AX]),
        .bx     (regs_q[REG_BX]),
        .dx     (regs_q[REG_DX]),
        .lx     (regs_q[REG_LX]),
        .rdata  (data_rdata),
        .wr     (slot_wr[SLOT_XFER]),
        .st_en  (st_en),
        .st_val (st_val)
    );

    arith_slot u_arith (
        .code (slot_code[SLOT_ARITH]),
        .ax   (regs_q[REG_AX]),
        .bx   (regs_q[REG_BX]),
        .dx   (regs_q[REG_DX]),
        .wr   (slot_wr[SLOT_ARITH])
    );

    flow_slot u_flow (
        .code (slot_code[SLOT_FLOW]),
        .ip   (regs_q[REG_IP]),
        .lx   (regs_q[REG_LX]),
        .cf   (cf_q),
        .wr   (slot_wr[SLOT_FLOW])
    );

    slot_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (slot_wr),
        .regs  (regs_q),
        .cf    (cf_q)
    );

    assign code_addr  = regs_q[REG_IP];
    assign data_addr  = regs_q[REG_MA];
    assign data_we    = st_en;
    assign data_wdata = st_val;

endmodule

// File: rtl/tri_slot_core_checker.sv
// Checker bound to the core: decodes the opcode on its own and relates it
// to the registers and ports one cycle later.
module tri_slot_core_checker
    import tri_slot_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input word_t code_rdata,
    input word_t code_addr,
    input word_t data_addr,
    input logic  data_we,
    input word_t ax,
    input word_t bx,
    input word_t dx,
    input word_t lx,
    input logic  cf
);

    logic primed = 1'b0;
    logic [FIELD_W-1:0] fm;
    logic [FIELD_W-1:0] fa;
    logic [LAST_W-1:0]  ff;
    logic cad_op;
    logic ip_load;

    assign fm      = code_rdata[FIELD_W-1:0];
    assign fa      = code_rdata[2*FIELD_W-1:FIELD_W];
    assign ff      = code_rdata[WORD_W-1 -: LAST_W];
    assign cad_op  = (ff == LAST_W'(F_CAD));
    assign ip_load = (fm == X_AX_IP);

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) primed <= 1'b1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        (primed && $past(!rst_n)) |-> (code_addr == '0 && data_addr == '0 && !cf
                                       && ax == '0 && bx == '0 && dx == '0 && lx == '0));

    assert_ip_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ip_load && !(cad_op && cf)) |=> (code_addr == $past(code_addr) + 16'd1));

    assert_store_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_we == (fm == X_ST_AX || fm == X_ST_BX || fm == X_ST_DX || fm == X_ST_LX));

    assert_bx_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fm == X_BX_CF && ff != LAST_W'(F_CLR_CF) && ff != LAST_W'(F_SET_CF))
        |=> (cf == ($past(bx) != '0)));

    assert_cad_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cad_op && cf && !ip_load) |=> (code_addr == $past(code_addr + lx)));

    assert_ip_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_load && !cad_op) |=> (code_addr == $past(ax)));

    assert_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fa == A_XCH && fm != X_LD_DX) |=> (bx == $past(dx) && dx == $past(bx)));

endmodule

bind tri_slot_core tri_slot_core_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_rdata (code_rdata),
    .code_addr  (code_addr),
    .data_addr  (data_addr),
    .data_we    (data_we),
    .ax         (regs_q[tri_slot_pkg::REG_AX]),
    .bx         (regs_q[tri_slot_pkg::REG_BX]),
    .dx         (regs_q[tri_slot_pkg::REG_DX]),
    .lx         (regs_q[tri_slot_pkg::REG_LX]),
    .cf         (cf_q)
);

// File: tb/tri_slot_core_bench.sv
// Bench: feeds opcodes directly as the code memory, models a 256-word data
// memory, and compares every cycle against a parallel-assignment model.
module tri_slot_core_bench;
    import tri_slot_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] code_addr, code_rdata, data_addr, data_rdata, data_wdata;
    logic        data_we;
    logic [15:0] dmem [256];
    int          nchecks = 0;
    int          nerr = 0;
    logic [15:0] m_ax, m_bx, m_dx, m_lx, m_ma, m_ip;
    logic        m_cf;

    always #5ns clk = ~clk;

    assign data_rdata = dmem[data_addr[7:0]];

    tri_slot_core u_tri_slot_core (
        .clk(clk), .rst_n(rst_n),
        .code_addr(code_addr), .code_rdata(code_rdata),
        .data_addr(data_addr), .data_rdata(data_rdata),
        .data_we(data_we), .data_wdata(data_wdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int m, input int a, input int f);
        logic [5:0] ff = f[5:0];
        logic [4:0] fa = a[4:0];
        logic [4:0] fm = m[4:0];
        return {ff, fa, fm};
    endfunction

    function automatic bit legal(input int m, input int a, input int f);
        if (m == X_LD_AX && (a == A_INC_AX || a == A_DEC_AX || a == A_ADD_BX)) return 1'b0;
        if (m == X_LD_DX && a == A_XCH) return 1'b0;
        if (m == X_LD_LX && a == A_LX_M1) return 1'b0;
        if (m == X_BX_CF && (f == F_CLR_CF || f == F_SET_CF)) return 1'b0;
        if (m == X_AX_IP && f == F_CAD) return 1'b0;
        return 1'b1;
    endfunction

    // One opcode: check state ports, drive, check store, model next state.
    task automatic step(input logic [15:0] op, input string tag,
                        input bit lit_en = 1'b0, input logic [15:0] lit = 16'h0);
        logic [4:0]  xm, xa;
        logic [5:0]  xf;
        logic [15:0] rd, e_wd;
        logic [15:0] n_ax, n_bx, n_dx, n_lx, n_ma, n_ip;
        logic        n_cf, e_we;
        chk(code_addr == m_ip, tag, "code_addr", code_addr, m_ip);
        chk(data_addr == m_ma, tag, "data_addr", data_addr, m_ma);
        code_rdata = op;
        #1ns;
        xm = op[4:0]; xa = op[9:5]; xf = op[15:10];
        rd = dmem[m_ma[7:0]];
        e_we = 1'b0; e_wd = 16'h0;
        n_ax = m_ax; n_bx = m_bx; n_dx = m_dx; n_lx = m_lx; n_ma = m_ma;
        n_ip = m_ip + 16'd1; n_cf = m_cf;
        case (xm)
            X_LD_AX: n_ax = rd;
            X_LD_DX: n_dx = rd;
            X_LD_LX: n_lx = rd;
            X_ST_AX: begin e_we = 1'b1; e_wd = m_ax; end
            X_ST_BX: begin e_we = 1'b1; e_wd = m_bx; end
            X_ST_DX: begin e_we = 1'b1; e_wd = m_dx; end
            X_ST_LX: begin e_we = 1'b1; e_wd = m_lx; end
            X_AX_MA: n_ma = m_ax;
            X_DX_MA: n_ma = m_dx;
            X_BX_CF: n_cf = (m_bx != 16'h0);
            X_AX_IP: n_ip = m_ax;
            default: ;
        endcase
        case (xa)
            A_INC_AX: n_ax = m_ax + 16'd1;
            A_DEC_AX: n_ax = m_ax - 16'd1;
            A_INC_BX: n_bx = m_bx + 16'd1;
            A_DEC_BX: n_bx = m_bx - 16'd1;
            A_XCH:    begin n_bx = m_dx; n_dx = m_bx; end
            A_LX_M1:  n_lx = 16'hFFFF;
            A_ADD_BX: n_ax = m_ax + m_bx;
            default: ;
        endcase
        case (xf)
            6'd1: if (m_cf) n_ip = m_ip + m_lx;
            6'd2: n_cf = 1'b0;
            6'd3: n_cf = 1'b1;
            default: ;
        endcase
        chk(data_we == e_we, tag, "data_we", {15'h0, data_we}, {15'h0, e_we});
        if (e_we) chk(data_wdata == e_wd, tag, "data_wdata", data_wdata, e_wd);
        if (lit_en) chk(data_we && data_wdata == lit, tag, "stored value", data_wdata, lit);
        @(posedge clk);
        @(negedge clk);
        if (e_we) dmem[m_ma[7:0]] = e_wd;
        m_ax = n_ax; m_bx = n_bx; m_dx = n_dx; m_lx = n_lx;
        m_ma = n_ma; m_ip = n_ip; m_cf = n_cf;
    endtask

    task automatic observe(input string tag);
        step(mk(X_ST_AX, 0, 0), tag);
        step(mk(X_ST_BX, 0, 0), tag);
        step(mk(X_ST_DX, 0, 0), tag);
        step(mk(X_ST_LX, 0, 0), tag);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin : main
        logic [15:0] p, s_ax, s_bx, s_dx, s_lx;
        int m_list [14] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 13, 31};
        int a_list [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 31};
        int f_list [7]  = '{0, 1, 2, 3, 4, 32, 63};
        for (int i = 0; i < 256; i++) dmem[i] = 16'(i * 37 + 5);
        rst_n = 1'b0;
        code_rdata = 16'h0;
        m_ax = 0; m_bx = 0; m_dx = 0; m_lx = 0; m_ma = 0; m_ip = 0; m_cf = 0;
        repeat (3) @(negedge clk);
        chk(code_addr == 16'h0, "R1", "code_addr in reset", code_addr, 16'h0);
        chk(data_addr == 16'h0, "R1", "data_addr in reset", data_addr, 16'h0);
        rst_n = 1'b1;

        // R1: all data registers read zero after reset
        step(mk(X_ST_AX, 0, 0), "R1", 1'b1, 16'h0);
        step(mk(X_ST_BX, 0, 0), "R1", 1'b1, 16'h0);
        step(mk(X_ST_DX, 0, 0), "R1", 1'b1, 16'h0);
        step(mk(X_ST_LX, 0, 0), "R1", 1'b1, 16'h0);
        // R2: plain increment of IP
        step(16'h0, "R2");
        step(16'h0, "R2");
        chk(code_addr == 16'd6, "R2", "code_addr after 6 opcodes", code_addr, 16'd6);
        // R5: no strobe without a store code
        step(mk(0, A_INC_AX, 0), "R5");
        // R10: arithmetic with wrap
        step(mk(0, A_DEC_BX, 0), "R10");
        step(mk(X_ST_BX, 0, 0), "R10", 1'b1, 16'hFFFF);
        step(mk(0, A_ADD_BX, 0), "R10");
        step(mk(X_ST_AX, 0, 0), "R10", 1'b1, 16'h0000);
        step(mk(0, A_DEC_AX, 0), "R10");
        step(mk(X_ST_AX, 0, 0), "R10", 1'b1, 16'hFFFF);
        step(mk(0, A_INC_BX, 0), "R10");
        step(mk(0, A_INC_BX, 0), "R10");
        step(mk(X_ST_BX, 0, 0), "R10", 1'b1, 16'h0001);
        step(mk(0, A_DEC_BX, 0), "R10");
        // R11: constant and exchange
        step(mk(0, A_LX_M1, 0), "R11");
        step(mk(X_ST_LX, 0, 0), "R11", 1'b1, 16'hFFFF);
        step(mk(0, A_DEC_BX, 0), "R11");
        step(mk(0, A_XCH, 0), "R11");
        step(mk(X_ST_DX, 0, 0), "R11", 1'b1, 16'hFFFF);
        step(mk(X_ST_BX, 0, 0), "R11", 1'b1, 16'h0000);
        // R6: MA from AX
        step(mk(X_AX_MA, 0, 0), "R6");
        chk(data_addr == 16'hFFFF, "R6", "data_addr from AX", data_addr, 16'hFFFF);
        // R4: loads from location 255
        step(mk(X_LD_DX, 0, 0), "R4");
        step(mk(X_ST_DX, 0, 0), "R4", 1'b1, 16'h24E0);
        step(mk(X_LD_LX, 0, 0), "R4");
        step(mk(X_ST_LX, 0, 0), "R4", 1'b1, 16'h24E0);
        step(mk(X_DX_MA, A_LX_M1, 0), "R6");
        chk(data_addr == 16'h24E0, "R6", "data_addr from DX", data_addr, 16'h24E0);
        // R12 + R7: flag from old BX (0) while BX increments
        step(mk(X_BX_CF, A_INC_BX, 0), "R12");
        p = code_addr;
        step(mk(0, 0, F_CAD), "R7");
        chk(code_addr == p + 16'd1, "R7", "branch not taken for BX=0", code_addr, p + 16'd1);
        step(mk(X_BX_CF, 0, 0), "R7");
        p = code_addr;
        step(mk(0, 0, F_CAD), "R8");
        chk(code_addr == p - 16'd1, "R8", "branch back by one", code_addr, p - 16'd1);
        // R13: explicit flag control
        step(mk(0, 0, F_CLR_CF), "R13");
        p = code_addr;
        step(mk(0, 0, F_CAD), "R13");
        chk(code_addr == p + 16'd1, "R13", "flag cleared", code_addr, p + 16'd1);
        step(mk(0, 0, F_SET_CF), "R13");
        p = code_addr;
        step(mk(0, 0, F_CAD), "R13");
        chk(code_addr == p - 16'd1, "R13", "flag set", code_addr, p - 16'd1);
        // R9: jump through AX then wrap of IP
        step(mk(X_AX_IP, 0, 0), "R9");
        chk(code_addr == 16'hFFFF, "R9", "IP from AX", code_addr, 16'hFFFF);
        step(16'h0, "R2");
        chk(code_addr == 16'h0000, "R2", "IP wrap", code_addr, 16'h0000);
        // R12: pre-edge values seen by other fields
        step(mk(X_ST_BX, A_XCH, 0), "R12", 1'b1, m_bx);
        s_ax = m_ax;
        step(mk(X_AX_MA, A_INC_AX, 0), "R12");
        chk(data_addr == s_ax, "R12", "MA takes old AX", data_addr, s_ax);
        step(mk(X_ST_AX, A_DEC_AX, F_SET_CF), "R12", 1'b1, m_ax);
        // R3: unused codes and all-ones opcode change nothing
        s_ax = m_ax; s_bx = m_bx; s_dx = m_dx; s_lx = m_lx;
        step(16'hFFFF, "R3");
        step(mk(20, 25, 5), "R3");
        step(mk(0, 0, 33), "R3");
        step(mk(X_ST_AX, 0, 0), "R3", 1'b1, s_ax);
        step(mk(X_ST_BX, 0, 0), "R3", 1'b1, s_bx);
        step(mk(X_ST_DX, 0, 0), "R3", 1'b1, s_dx);
        step(mk(X_ST_LX, 0, 0), "R3", 1'b1, s_lx);

        // R12: sweep of every legal field combination, state observed after each
        for (int pass = 0; pass < 2; pass++) begin
            for (int im = 0; im < 14; im++) begin
                for (int ia = 0; ia < 10; ia++) begin
                    for (int jf = 0; jf < 7; jf++) begin
                        if (legal(m_list[im], a_list[ia], f_list[jf])) begin
                            step(mk(m_list[im], a_list[ia], f_list[jf]), "R12");
                            observe("R12");
                        end
                    end
                end
            end
            step(mk(X_LD_AX, 0, 0), "R4");
            step(mk(X_LD_DX, A_INC_BX, 0), "R4");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule